// File: doc/BRIEF.md
# Two-Level Page Walker

This block turns a 32-bit virtual address into a physical address. It walks a directory/table pair held in ordinary memory. A requester offers a virtual address, a write flag and a two-bit privilege level. When translation is switched on, the block reads the directory entry. It then reads the table entry too, unless the directory entry maps a 4 MB page by itself. It checks presence, write permission and user permission. It answers with either a physical address or a fault. A fault carries a three-bit cause code, and the faulting address is copied into a register that stays readable until the next fault.

The block holds two configuration registers. The first is a control word, in which bit 31 turns translation on and bit 0 turns protection on. The second is the directory base. Entry reads and the write-back that sets the accessed/dirty bits both go out on one valid/ready memory port. Read data is taken in the same cycle as the handshake. When translation is off, the virtual address is returned unchanged and memory is not touched.

Top module: `pt_walker`

## Requirements
- R1: Translation is active only while both control bit 31 and control bit 0 are set (bit 31 is paging, bit 0 is protection). When it is not active, a request completes with the physical address equal to the virtual address. The response arrives one cycle after acceptance, with no memory access and no fault.
- R2: The directory entry is read at {base[31:12], va[31:22], 2'b00}. Bits 11:0 written to the base register are ignored.
- R3: For a directory entry with bit 7 = 0, the table entry is read at {dir_entry[31:12], va[21:12], 2'b00}.
- R4: For a 4 KB mapping, the physical address is {table_entry[31:12], va[11:0]}.
- R5: A present directory entry with bit 7 = 1 maps a 4 MB page. The physical address is {dir_entry[31:22], va[21:0]}, and only one entry is read.
- R6: An entry with bit 0 (present) clear, at either level, raises a fault whose code has bit 0 = 0.
- R7: Bit 1 of an entry means writable. A write faults unless bit 1 is set in every entry on the path, and this holds for all privilege levels. The fault code has bit 0 = 1.
- R8: Bit 2 of an entry means user. An access at privilege level 3 faults unless bit 2 is set in every entry on the path. Levels 0 to 2 skip this check.
- R9: The fault code has bit 0 = 1 for a permission violation and 0 for a not-present entry. Bit 1 = 1 for a write, and bit 2 = 1 for a level-3 access. All other bits are 0, and the code is 0 on success.
- R10: On every fault, the faulting virtual address is loaded into the fault-address output. That output holds its value at all other times.
- R11: A successful walk writes the final entry back with bit 5 (accessed) set, and with bit 6 (dirty) set as well when the access is a write. The write-back happens only if bit 5 was clear, or if the access is a write and bit 6 was clear. A faulting walk writes nothing.
- R12: A memory request, meaning its address, write flag and write data, is held unchanged until mem_ready is seen.
- R13: After reset, translation is off, the base is 0, the fault address is 0, req_ready is 1, and neither rsp_valid nor mem_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_load | input | 1 | Load the control word |
| ctrl_data | input | 32 | Control word (bit 31 paging, bit 0 protection) |
| root_load | input | 1 | Load the directory base |
| root_data | input | 32 | Directory base physical address |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_cpl | input | 2 | Privilege level (3 = user) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_ecode | output | 32 | Fault cause code |
| fault_addr | output | 32 | Last faulting virtual address |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts (and supplies read data) |
| mem_write | output | 1 | Request is the entry write-back |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Entry read data, valid with the handshake |

## Verification
When translation is off, the response is due exactly one cycle after the request is accepted. The bench counts the clock edges between acceptance and rsp_valid and requires a count of one. A walk responds one cycle after its last memory handshake. Because the memory model stalls on a fixed pattern, the bench waits for rsp_valid under a watchdog rather than predicting the exact cycle. All outputs, and the logged memory addresses and write-backs, are sampled on the falling edge, so each result is stable from the edge that produced it.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_load,
  input  logic [31:0] ctrl_data,
  input  logic        root_load,
  input  logic [31:0] root_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_ecode,
  output logic [31:0] fault_addr,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int P_BIT = 0;
  localparam int W_BIT = 1;
  localparam int U_BIT = 2;
  localparam int A_BIT = 5;
  localparam int D_BIT = 6;
  localparam int S_BIT = 7;

  typedef enum logic [2:0] {IDLE, DIR, TBL, WB, RSP} st_t;
  st_t state;

  logic        pg_on, pe_on;
  logic [19:0] root_q, pde_base;
  logic        pde_w, pde_u;
  logic [31:0] va_q, pa_q, wb_q, wb_addr_q, fa_q;
  logic        wr_q, usr_q, flt_q;
  logic [2:0]  code_q;

  wire xlate_on = pg_on & pe_on;
  wire in_dir   = (state == DIR);
  wire [31:0] e = mem_rdata;

  wire eff_w = in_dir ? e[W_BIT] : (pde_w & e[W_BIT]);
  wire eff_u = in_dir ? e[U_BIT] : (pde_u & e[U_BIT]);
  wire viol  = (wr_q & ~eff_w) | (usr_q & ~eff_u);
  wire need_wb = ~e[A_BIT] | (wr_q & ~e[D_BIT]);
  wire [31:0] leaf_pa = in_dir ? {e[31:22], va_q[21:0]} : {e[31:12], va_q[11:0]};
  wire [31:0] wb_data = e | (32'd1 << A_BIT) | ({31'd0, wr_q} << D_BIT);

  logic unused_bits;
  assign unused_bits = ^{ctrl_data[30:1], root_data[11:0], e[11:8], e[4:3]};

  assign req_ready  = (state == IDLE);
  assign rsp_valid  = (state == RSP);
  assign rsp_fault  = flt_q;
  assign rsp_paddr  = pa_q;
  assign rsp_ecode  = {29'd0, code_q};
  assign fault_addr = fa_q;
  assign mem_valid  = (state == DIR) || (state == TBL) || (state == WB);
  assign mem_write  = (state == WB);
  assign mem_wdata  = wb_q;

  always_comb begin
    case (state)
      DIR:     mem_addr = {root_q, va_q[31:22], 2'b00};
      TBL:     mem_addr = {pde_base, va_q[21:12], 2'b00};
      WB:      mem_addr = wb_addr_q;
      default: mem_addr = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      pg_on <= 1'b0;
      pe_on <= 1'b0;
      root_q <= '0;
      pde_base <= '0;
      pde_w <= 1'b0;
      pde_u <= 1'b0;
      va_q <= '0;
      pa_q <= '0;
      wb_q <= '0;
      wb_addr_q <= '0;
      fa_q <= '0;
      wr_q <= 1'b0;
      usr_q <= 1'b0;
      flt_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (ctrl_load) begin
        pg_on <= ctrl_data[31];
        pe_on <= ctrl_data[0];
      end
      if (root_load) root_q <= root_data[31:12];
      case (state)
        IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          usr_q <= (req_cpl == 2'd3);
          if (xlate_on) state <= DIR;
          else begin
            pa_q   <= req_vaddr;
            flt_q  <= 1'b0;
            code_q <= '0;
            state  <= RSP;
          end
        end
        DIR, TBL: if (mem_ready) begin
          if (in_dir && e[P_BIT] && !e[S_BIT]) begin
            pde_base <= e[31:12];
            pde_w    <= e[W_BIT];
            pde_u    <= e[U_BIT];
            state    <= TBL;
          end else if (!e[P_BIT] || viol) begin
            flt_q  <= 1'b1;
            code_q <= {usr_q, wr_q, e[P_BIT]};
            fa_q   <= va_q;
            state  <= RSP;
          end else begin
            flt_q  <= 1'b0;
            code_q <= '0;
            pa_q   <= leaf_pa;
            if (need_wb) begin
              wb_q      <= wb_data;
              wb_addr_q <= mem_addr;
              state     <= WB;
            end else state <= RSP;
          end
        end
        WB:  if (mem_ready) state <= RSP;
        RSP: state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlate_on) |=>
      (rsp_valid && !rsp_fault && !mem_valid && rsp_paddr == $past(req_vaddr)));

  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  assert_wb_accessed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_wdata[A_BIT] && mem_wdata[P_BIT]));

  assert_ok_code_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_ecode == 32'd0));

  assert_fault_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (fault_addr == va_q));

  assert_fault_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> (rsp_valid && rsp_fault));
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_load = 1'b0, root_load = 1'b0;
  logic [31:0] ctrl_data = '0, root_data = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0] req_cpl = '0;
  logic req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr, rsp_ecode, fault_addr;
  logic mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .ctrl_load(ctrl_load), .ctrl_data(ctrl_data),
    .root_load(root_load), .root_data(root_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_cpl(req_cpl),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_ecode(rsp_ecode), .fault_addr(fault_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [0:4095];
  logic [1:0] sc = 2'd0;
  int nrd = 0, nwr = 0, hold_err = 0;
  logic [31:0] rdlog [0:3];
  logic prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  assign mem_ready = (sc != 2'd1);
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    sc <= sc + 2'd1;
    if (prev_stall && (!mem_valid || mem_addr != prev_addr)) hold_err++;
    prev_stall <= mem_valid && !mem_ready;
    prev_addr  <= mem_addr;
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        nwr++;
      end else begin
        if (nrd < 4) rdlog[nrd] = mem_addr;
        nrd++;
      end
    end
  end

  int checks = 0, fails = 0;
  logic [31:0] r_pa, r_code, r_fa;
  logic r_flt;
  int r_lat;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [31:0] d);
    @(negedge clk); ctrl_load = 1'b1; ctrl_data = d;
    @(negedge clk); ctrl_load = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr, input logic [1:0] cpl);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_cpl = cpl;
    nrd = 0; nwr = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!rsp_valid) begin @(negedge clk); r_lat++; end
    r_pa = rsp_paddr; r_flt = rsp_fault; r_code = rsp_ecode; r_fa = fault_addr;
  endtask

  // {va, write, cpl, fault, pa, code}
  localparam logic [70:0] VEC [13] = '{
    {32'h00000123, 1'b0, 2'd3, 1'b0, 32'h00050123, 3'd0},
    {32'h00001456, 1'b0, 2'd0, 1'b0, 32'h00060456, 3'd0},
    {32'h00001456, 1'b0, 2'd3, 1'b1, 32'h0,        3'd5}, // R8
    {32'h00002010, 1'b1, 2'd3, 1'b1, 32'h0,        3'd7}, // R7
    {32'h00002010, 1'b0, 2'd3, 1'b0, 32'h00070010, 3'd0},
    {32'h00003000, 1'b0, 2'd0, 1'b1, 32'h0,        3'd0}, // R6 table level
    {32'h00C00000, 1'b1, 2'd3, 1'b1, 32'h0,        3'd6}, // R6 directory level
    {32'h00400ABC, 1'b1, 2'd0, 1'b1, 32'h0,        3'd3}, // R7 directory read-only
    {32'h00400ABC, 1'b0, 2'd3, 1'b0, 32'h000A0ABC, 3'd0},
    {32'h00923456, 1'b1, 2'd0, 1'b0, 32'h0C123456, 3'd0}, // R5
    {32'h00923456, 1'b0, 2'd3, 1'b1, 32'h0,        3'd5}, // R8 large page
    {32'hFFC00010, 1'b1, 2'd3, 1'b0, 32'h7FC00010, 3'd0},
    {32'h00005FFF, 1'b1, 2'd3, 1'b0, 32'h00090FFF, 3'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", fails, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    mem[12'h400] = 32'h00002007;
    mem[12'h401] = 32'h00003005;
    mem[12'h402] = 32'h0C000083;
    mem[12'h7FF] = 32'h7FC000A7;
    mem[12'h800] = 32'h00050007;
    mem[12'h801] = 32'h00060003;
    mem[12'h802] = 32'h00070005;
    mem[12'h803] = 32'h00080006;
    mem[12'h805] = 32'h00090067;
    mem[12'hC00] = 32'h000A0007;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 ready", {31'd0, req_ready}, 32'd1);
    chk("R13 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R13 mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R13 fault_addr", fault_addr, 32'd0);

    xlate(32'h12345678, 1'b1, 2'd3);
    chk("R1 off paddr", r_pa, 32'h12345678);
    chk("R1 off latency", r_lat, 1);
    chk("R1 off no memory", nrd + nwr, 0);
    set_ctrl(32'h80000000);
    xlate(32'hDEADB000, 1'b0, 2'd0);
    chk("R1 paging-only paddr", r_pa, 32'hDEADB000);
    chk("R1 paging-only fault", {31'd0, r_flt}, 32'd0);
    set_ctrl(32'h00000001);
    xlate(32'h00C00000, 1'b1, 2'd3);
    chk("R1 protect-only paddr", r_pa, 32'h00C00000);
    chk("R1 protect-only no memory", nrd + nwr, 0);

    @(negedge clk); root_load = 1'b1; root_data = 32'h00001ABC;
    @(negedge clk); root_load = 1'b0;
    set_ctrl(32'h80000001);
    xlate(32'h00000123, 1'b0, 2'd3);
    chk("R4 paddr", r_pa, 32'h00050123);
    chk("R2 directory address", rdlog[0], 32'h00001000);
    chk("R3 table address", rdlog[1], 32'h00002000);
    chk("R11 one write-back", nwr, 1);
    chk("R11 accessed set", mem[12'h800], 32'h00050027);

    for (int i = 0; i < 13; i++) begin
      xlate(VEC[i][70:39], VEC[i][38], VEC[i][37:36]);
      chk($sformatf("R6/R7/R8 fault flag vector %0d", i), {31'd0, r_flt}, {31'd0, VEC[i][35]});
      if (VEC[i][35]) begin
        chk($sformatf("R9 code vector %0d", i), r_code, {29'd0, VEC[i][2:0]});
        chk($sformatf("R10 fault address vector %0d", i), r_fa, VEC[i][70:39]);
      end else begin
        chk($sformatf("R4/R5 paddr vector %0d", i), r_pa, VEC[i][34:3]);
        chk($sformatf("R9 zero code vector %0d", i), r_code, 32'd0);
      end
    end

    @(negedge clk);
    chk("R11 dirty large page", mem[12'h7FF], 32'h7FC000E7);
    chk("R11 large write-back", mem[12'h402], 32'h0C0000E3);
    chk("R11 untouched entry", mem[12'h805], 32'h00090067);
    chk("R11 table1 accessed", mem[12'hC00], 32'h000A0027);

    xlate(32'h00923456, 1'b0, 2'd0);
    chk("R5 large paddr", r_pa, 32'h0C123456);
    chk("R5 single read", nrd, 1);
    chk("R11 no write when accessed", nwr, 0);

    xlate(32'h00002010, 1'b1, 2'd3);
    chk("R7 write fault", {31'd0, r_flt}, 32'd1);
    chk("R3 indexed table address", rdlog[1], 32'h00002008);
    chk("R11 no write on fault", nwr, 0);
    chk("R10 loaded", r_fa, 32'h00002010);

    xlate(32'h00000123, 1'b1, 2'd3);
    @(negedge clk);
    chk("R11 dirty write-back", nwr, 1);
    chk("R11 dirty set", mem[12'h800], 32'h00050067);
    chk("R10 held on success", fault_addr, 32'h00002010);
    xlate(32'h00000123, 1'b1, 2'd3);
    chk("R11 no repeat write", nwr, 0);

    chk("R12 request held while stalled", hold_err, 0);

    $display("  Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule